// File: doc/BRIEF.md
# Isochronous IN Endpoint Transmit Control

This block holds the control/status word and the transmit byte queue for one isochronous IN endpoint of a USB device controller. Firmware fills the queue one byte at a time and watches a room flag that says whether another full packet fits. A packet engine on the far side takes bytes out, says when it starts a packet and when a packet has gone out, and may ask for a byte when none is left.

The status word mixes several kinds of bits. The room flag is read-only. The packet-sent and underrun flags are sticky and are cleared by writing 1. The flush command runs for a single cycle and always reads back 0. The short-packet request is set by writing 1 and is cleared by hardware. Every bit that has no assigned function reads as zero.

Top module: `iso_tx_ep_ctrl`

## Requirements
- R1: After reset the status word reads 0x0000_0001, `tx_short` is 0 and `eng_valid` is 0.
- R2: Bit 0 (room) reads 1 when at least 256 bytes of the 512-byte queue are free (256 or fewer stored). It reads 0 when 257 or more bytes are stored.
- R3: Bit 1 (packet sent) reads 1 from the cycle after an `eng_done` pulse. It stays set until a register write with bit 1 = 1, and a write with bit 1 = 0 leaves it unchanged.
- R4: Bit 3 (underrun) reads 1 from the cycle after `eng_pop` is asserted while the queue is empty. It stays set until a register write with bit 3 = 1, and a write with bit 3 = 0 leaves it unchanged.
- R5: A register write with bit 2 = 1 empties the queue (room = 1, `eng_valid` = 0) and clears bit 7. Bit 2 always reads 0.
- R6: A register write with bit 7 = 1 sets bit 7 and `tx_short`. An `eng_start` pulse clears both. A write with bit 7 = 0 leaves them unchanged.
- R7: Bits 4, 5, 6 and 31:8 read 0 whatever value is written.
- R8: Bytes leave on `eng_data` in the order they were pushed, and `eng_valid` is 1 exactly when the queue holds at least one byte.
- R9: A push into a full queue (512 bytes) is dropped.
- R10: When a hardware set event (`eng_done` or an empty pop) arrives in the same cycle as a write-1 clear of the same flag, the flag ends up set.
- R11: A push in the same cycle as a flush is dropped, and a set of bit 7 written together with a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Status word write strobe |
| reg_wdata | input | 32 | Status word write data |
| reg_rdata | output | 32 | Current status word |
| fifo_push | input | 1 | Push one byte into the queue |
| fifo_wdata | input | 8 | Byte to push |
| eng_start | input | 1 | Packet engine begins a packet |
| eng_pop | input | 1 | Packet engine takes the byte on `eng_data` |
| eng_done | input | 1 | Packet engine finished sending a packet |
| eng_data | output | 8 | Oldest queued byte |
| eng_valid | output | 1 | Queue is not empty |
| tx_short | output | 1 | Short-packet request pending |

## Verification
If the occupancy count is wrong, the room bit shows it as soon as the count crosses 256 stored bytes. The count also shows at `eng_valid` on the cycle after the last real byte is taken, and a leaked extra byte keeps `eng_valid` high. A sticky flag stuck in the wrong state shows in `reg_rdata` one cycle after the event or the clear write. A pointer error shows as a byte out of order on the next pop. If the flush leaves state behind, the room bit and `eng_valid` show it on the cycle right after the flush write.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;
  localparam int REG_W = 32;

  // bit positions inside the status word, fixed by software decoding
  localparam int B_ROOM  = 0;
  localparam int B_SENT  = 1;
  localparam int B_FLUSH = 2;
  localparam int B_UNDER = 3;
  localparam int B_SHORT = 7;

  typedef struct packed {
    logic room;
    logic sent;
    logic under;
    logic short_req;
  } csr_state_t;

  function automatic logic room_ok(input int unsigned depth,
                                   input int unsigned pkt,
                                   input int unsigned used);
    return (depth - used) >= pkt;
  endfunction

  function automatic logic [REG_W-1:0] pack_csr(input csr_state_t s);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_ROOM]  = s.room;
    w[B_SENT]  = s.sent;
    w[B_UNDER] = s.under;
    w[B_SHORT] = s.short_req;
    return w;
  endfunction
endpackage

// File: rtl/iso_tx_fifo.sv
module iso_tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     count,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              full;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = pop && !empty && !flush;
  assign push_ok = push && !flush && (!full || pop_ok);
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/iso_tx_flag.sv
module iso_tx_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  logic nxt;

  generate
    if (SET_WINS) begin : g_set_pri
      assign nxt = set_i ? 1'b1 : (clr_i ? 1'b0 : q);
    end else begin : g_clr_pri
      assign nxt = clr_i ? 1'b0 : (set_i ? 1'b1 : q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/iso_tx_csr.sv
module iso_tx_csr
  import iso_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             room,
  input  logic             sent_evt,
  input  logic             under_evt,
  input  logic             start_evt,
  output logic             flush_evt,
  output logic             sent_clr_evt,
  output logic             under_clr_evt,
  output logic             short_set_evt,
  output logic             short_q,
  output logic [REG_W-1:0] rdata
);
  logic sent_q, under_q;
  csr_state_t st;

  assign flush_evt     = reg_wr && reg_wdata[B_FLUSH];
  assign sent_clr_evt  = reg_wr && reg_wdata[B_SENT];
  assign under_clr_evt = reg_wr && reg_wdata[B_UNDER];
  assign short_set_evt = reg_wr && reg_wdata[B_SHORT] && !flush_evt;

  iso_tx_flag #(.SET_WINS(1'b1)) u_sent (
    .clk(clk), .rst_n(rst_n), .set_i(sent_evt), .clr_i(sent_clr_evt), .q(sent_q));

  iso_tx_flag #(.SET_WINS(1'b1)) u_under (
    .clk(clk), .rst_n(rst_n), .set_i(under_evt), .clr_i(under_clr_evt), .q(under_q));

  iso_tx_flag #(.SET_WINS(1'b1)) u_short (
    .clk(clk), .rst_n(rst_n), .set_i(short_set_evt),
    .clr_i(start_evt || flush_evt), .q(short_q));

  always_comb begin
    st.room      = room;
    st.sent      = sent_q;
    st.under     = under_q;
    st.short_req = short_q;
    rdata        = pack_csr(st);
  end
endmodule

// File: rtl/iso_tx_ep_ctrl.sv
module iso_tx_ep_ctrl
  import iso_tx_pkg::*;
#(
  parameter int PKT_BYTES = 256,
  parameter int PKTS      = 2,
  parameter int DATA_W    = 8,
  localparam int DEPTH = PKT_BYTES * PKTS,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              fifo_push,
  input  logic [DATA_W-1:0] fifo_wdata,
  input  logic              eng_start,
  input  logic              eng_pop,
  input  logic              eng_done,
  output logic [DATA_W-1:0] eng_data,
  output logic              eng_valid,
  output logic              tx_short
);
  logic [CW-1:0] fifo_count;
  logic fifo_empty, push_evt, pop_evt, underrun_evt, room;
  logic flush_evt, tpc_clr_evt, tur_clr_evt, tsp_set_evt;

  assign underrun_evt = eng_pop && fifo_empty;
  assign room         = room_ok(DEPTH, PKT_BYTES, int'(fifo_count));
  assign eng_valid    = !fifo_empty;

  iso_tx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush_evt),
    .push(fifo_push), .wdata(fifo_wdata),
    .pop(eng_pop), .rdata(eng_data), .count(fifo_count),
    .push_ok(push_evt), .pop_ok(pop_evt), .empty(fifo_empty));

  iso_tx_csr u_csr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .room(room), .sent_evt(eng_done), .under_evt(underrun_evt),
    .start_evt(eng_start), .flush_evt(flush_evt),
    .sent_clr_evt(tpc_clr_evt), .under_clr_evt(tur_clr_evt),
    .short_set_evt(tsp_set_evt), .short_q(tx_short), .rdata(reg_rdata));
endmodule

// File: rtl/iso_tx_ep_ctrl_chk.sv
module iso_tx_ep_ctrl_chk #(
  parameter int DEPTH = 512,
  parameter int CW    = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   reg_rdata,
  input logic          eng_done,
  input logic          eng_start,
  input logic          tx_short,
  input logic          eng_valid,
  input logic          underrun_evt,
  input logic          flush_evt,
  input logic          tpc_clr_evt,
  input logic          tsp_set_evt,
  input logic          push_evt,
  input logic [CW-1:0] fifo_count
);
  a_r3_sent_sets: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> reg_rdata[1]);
  a_r3_sent_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tpc_clr_evt && !eng_done) |=> !reg_rdata[1]);
  a_r4_under_sets: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |=> reg_rdata[3]);
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> (!eng_valid && reg_rdata[0] && !tx_short));
  a_r6_short_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !tsp_set_evt) |=> !tx_short);
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));
  a_r11_flush_drops_push: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |-> !push_evt);
endmodule

bind iso_tx_ep_ctrl iso_tx_ep_ctrl_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .eng_done(eng_done),
  .eng_start(eng_start), .tx_short(tx_short), .eng_valid(eng_valid),
  .underrun_evt(underrun_evt), .flush_evt(flush_evt),
  .tpc_clr_evt(tpc_clr_evt), .tsp_set_evt(tsp_set_evt),
  .push_evt(push_evt), .fifo_count(fifo_count));

// File: tb/iso_tx_ep_ctrl_test.sv
module iso_tx_ep_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic fifo_push = 1'b0;
  logic [7:0] fifo_wdata = '0;
  logic eng_start = 1'b0, eng_pop = 1'b0, eng_done = 1'b0;
  logic [7:0] eng_data;
  logic eng_valid, tx_short;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  iso_tx_ep_ctrl uut (.*);

  // {write data, expected status word after the write}
  localparam logic [63:0] VEC [6] = '{
    {32'h0000_0000, 32'h0000_0001},   // R6 R7 nothing set
    {32'h0000_0080, 32'h0000_0081},   // R6 set short request
    {32'h0000_0000, 32'h0000_0081},   // R6 zero write keeps it
    {32'hFFFF_FF70, 32'h0000_0081},   // R7 reserved stay 0
    {32'h0000_0004, 32'h0000_0001},   // R5 flush clears short request
    {32'h0000_000A, 32'h0000_0001}    // R3 R4 clearing clear flags
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d; tick(); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic push(input logic [7:0] b);
    fifo_push = 1'b1; fifo_wdata = b; tick(); fifo_push = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    b = eng_data; eng_pop = 1'b1; tick(); eng_pop = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int bad;
    tick(); tick(); rst_n = 1'b1; tick();
    // R1
    chk("R1 status", reg_rdata, 32'h1);
    chk("R1 short", {31'd0, tx_short}, 32'h0);
    chk("R1 valid", {31'd0, eng_valid}, 32'h0);

    foreach (VEC[i]) begin
      wr(VEC[i][63:32]);
      chk($sformatf("R5 R6 R7 vector %0d", i), reg_rdata, VEC[i][31:0]);
    end

    // R2 room boundary, R9 overflow drop, R8 ordering
    for (int i = 0; i < 256; i++) push(i[7:0]);
    chk("R2 room at 256", {31'd0, reg_rdata[0]}, 32'h1);
    push(8'd0);
    chk("R2 room at 257", {31'd0, reg_rdata[0]}, 32'h0);
    for (int i = 257; i < 513; i++) push(i[7:0]);
    bad = 0;
    for (int i = 0; i < 512; i++) begin
      pop(b);
      if (i != 256 && b !== i[7:0]) bad++;
      if (i == 256 && b !== 8'd0) bad++;
    end
    chk("R8 order mismatches", bad, 0);
    chk("R9 full push dropped", {31'd0, eng_valid}, 32'h0);

    // R4 underrun and clear
    pop(b);
    chk("R4 underrun set", reg_rdata, 32'h9);
    wr(32'h0);
    chk("R4 zero write keeps", reg_rdata, 32'h9);
    wr(32'h8);
    chk("R4 cleared", reg_rdata, 32'h1);

    // R3 packet sent and clear
    eng_done = 1'b1; tick(); eng_done = 1'b0;
    chk("R3 sent set", reg_rdata, 32'h3);
    wr(32'h0);
    chk("R3 zero write keeps", reg_rdata, 32'h3);
    wr(32'h2);
    chk("R3 cleared", reg_rdata, 32'h1);

    // R10 set beats clear
    eng_done = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h2; tick();
    eng_done = 1'b0; reg_wr = 1'b0;
    chk("R10 sent set wins", reg_rdata[1], 1'b1);
    eng_pop = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h8; tick();
    eng_pop = 1'b0; reg_wr = 1'b0;
    chk("R10 under set wins", reg_rdata[3], 1'b1);
    wr(32'hA);
    chk("R10 both cleared", reg_rdata, 32'h1);

    // R6 cleared by packet start
    wr(32'h80);
    chk("R6 tx_short set", {31'd0, tx_short}, 32'h1);
    eng_start = 1'b1; tick(); eng_start = 1'b0;
    chk("R6 start clears", reg_rdata, 32'h1);
    chk("R6 tx_short low", {31'd0, tx_short}, 32'h0);

    // R5 flush with data
    for (int i = 0; i < 300; i++) push(8'hA5);
    chk("R5 room before flush", {31'd0, reg_rdata[0]}, 32'h0);
    wr(32'h4);
    chk("R5 room after flush", reg_rdata, 32'h1);
    chk("R5 empty after flush", {31'd0, eng_valid}, 32'h0);

    // R11 push and short-set dropped by flush
    fifo_push = 1'b1; fifo_wdata = 8'h33; reg_wr = 1'b1; reg_wdata = 32'h84; tick();
    fifo_push = 1'b0; reg_wr = 1'b0;
    chk("R11 push dropped", {31'd0, eng_valid}, 32'h0);
    chk("R11 short dropped", reg_rdata, 32'h1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule